// File: doc/BRIEF.md
# Memory-Mapped Interrupt Trigger Register Block

This block is a small 32-bit register peripheral on a simple memory-mapped bus. The bus has a valid strobe, a write flag, a word address, write data and registered read data. The block holds five registers: two output data words, a control word, an interrupt status word and a software-interrupt word. It drives one level interrupt line toward the interrupt controller.

The line is not computed from status bits. It is a latch that specific writes set or clear directly. A two-state machine holds it.

- `LINE_LOW` is the reset state. The transition `RAISE` takes it to `LINE_HIGH`.
- `RAISE` fires on a write to output data B with bit 29 set, or on any write to the software-set offset.
- `LINE_HIGH` returns to `LINE_LOW` through the transition `DROP`.
- `DROP` fires on a write to control with bit 16 set, on a write to status with bit 16 or bit 29 set, or on any write to the software-clear offset.
- In every other cycle the machine stays in its state. A `RAISE` condition in `LINE_HIGH` or a `DROP` condition in `LINE_LOW` leaves it where it is.

Software uses the block as a doorbell. A driver raises the line by writing a command word, and its handler drops the line by acknowledging through the control or status register.

Top module: `irq_trigger_regs`

## Requirements
- R1: While reset is asserted and after it is released, the interrupt line is low. All five registers read zero, so control reads 0x0002_0000. The read data output is zero.
- R2: A read of control (offset 0x04C) returns the stored value with bit 17 forced to 1.
- R3: Full 32-bit words are stored at and read back from these offsets: output data A at 0x028, output data B at 0x02C, control at 0x04C and status at 0x050.
- R4: A write to output data B raises the line on the same clock edge if data bit 29 is 1. If bit 29 is 0, the line is left unchanged.
- R5: A write to control lowers the line if data bit 16 is 1. If bit 16 is 0, the line is left unchanged.
- R6: A write to status lowers the line if data bit 16 or bit 29 is 1. Otherwise the line is left unchanged.
- R7: A write to offset 0x1F0 ORs the data into the software-interrupt register and always raises the line, even when the data is zero.
- R8: A write to offset 0x1F4 clears the software-interrupt bits where the data is 1. It always lowers the line, even when the data is zero.
- R9: Reads of both 0x1F0 and 0x1F4 return the software-interrupt register.
- R10: A read of any other address returns zero. A write to any other address changes no register and leaves the line unchanged.
- R11: Reads and idle cycles leave the interrupt line unchanged.
- R12: Read data is registered. It appears one clock edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_out | output | 1 | Level interrupt line |

## Verification
Most internal faults in this block show up at the ports within one cycle.

- A wrong line state, such as a missed `RAISE` or `DROP` or a spurious change, appears on `irq_out` at the first sample after the triggering write edge.
- A register that was stored wrongly stays hidden until it is read back, then shows one edge after the read strobe.
- A decode fault that aliases an unknown address onto a real register shows either as non-zero read data at that address or as a corrupted value on a later read of the real register.

// File: rtl/itr_pkg.sv
package itr_pkg;

    localparam int OFF_W = 12;

    localparam logic [OFF_W-1:0] OFF_OUTA  = 12'h028;
    localparam logic [OFF_W-1:0] OFF_OUTB  = 12'h02C;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 12'h04C;
    localparam logic [OFF_W-1:0] OFF_STAT  = 12'h050;
    localparam logic [OFF_W-1:0] OFF_SWSET = 12'h1F0;
    localparam logic [OFF_W-1:0] OFF_SWCLR = 12'h1F4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OUTA,
        SEL_OUTB,
        SEL_CTRL,
        SEL_STAT,
        SEL_SWSET,
        SEL_SWCLR
    } reg_sel_e;

    typedef enum logic {
        LINE_LOW,
        LINE_HIGH
    } line_state_e;

endpackage

// File: rtl/itr_addr_decode.sv
module itr_addr_decode
    import itr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFF_OUTA)) begin
            sel = SEL_OUTA;
        end else if (addr == ADDR_W'(OFF_OUTB)) begin
            sel = SEL_OUTB;
        end else if (addr == ADDR_W'(OFF_CTRL)) begin
            sel = SEL_CTRL;
        end else if (addr == ADDR_W'(OFF_STAT)) begin
            sel = SEL_STAT;
        end else if (addr == ADDR_W'(OFF_SWSET)) begin
            sel = SEL_SWSET;
        end else if (addr == ADDR_W'(OFF_SWCLR)) begin
            sel = SEL_SWCLR;
        end
    end

endmodule

// File: rtl/itr_reg_bank.sv
module itr_reg_bank
    import itr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] outa_q,
    output logic [DATA_W-1:0] outb_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] swirq_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outa_q  <= '0;
            outb_q  <= '0;
            ctrl_q  <= '0;
            stat_q  <= '0;
            swirq_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_OUTA:  outa_q  <= wdata;
                SEL_OUTB:  outb_q  <= wdata;
                SEL_CTRL:  ctrl_q  <= wdata;
                SEL_STAT:  stat_q  <= wdata;
                SEL_SWSET: swirq_q <= swirq_q | wdata;
                SEL_SWCLR: swirq_q <= swirq_q & ~wdata;
                SEL_NONE:  ;
            endcase
        end
    end

endmodule

// File: rtl/itr_line_fsm.sv
module itr_line_fsm
    import itr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic drop,
    output logic line
);

    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW: begin
                if (raise) state_d = LINE_HIGH;
            end
            LINE_HIGH: begin
                if (drop) state_d = LINE_LOW;
            end
        endcase
    end

    always_comb begin
        line = (state_q == LINE_HIGH);
    end

endmodule

// File: rtl/itr_read_port.sv
module itr_read_port
    import itr_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int CTRL_FIXED_BIT = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] outa_q,
    input  logic [DATA_W-1:0] outb_q,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] stat_q,
    input  logic [DATA_W-1:0] swirq_q,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] CTRL_FORCE = DATA_W'(1) << CTRL_FIXED_BIT;

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_OUTA:  rd_mux = outa_q;
            SEL_OUTB:  rd_mux = outb_q;
            SEL_CTRL:  rd_mux = ctrl_q | CTRL_FORCE;
            SEL_STAT:  rd_mux = stat_q;
            SEL_SWSET: rd_mux = swirq_q;
            SEL_SWCLR: rd_mux = swirq_q;
            SEL_NONE:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_trigger_regs.sv
module irq_trigger_regs
    import itr_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int DATA_W         = 32,
    parameter int OUTB_RAISE_BIT = 29,
    parameter int CTRL_DROP_BIT  = 16,
    parameter int STAT_DROP_LO   = 16,
    parameter int STAT_DROP_HI   = 29,
    parameter int CTRL_FIXED_BIT = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    reg_sel_e          sel;
    logic              wr_en;
    logic              rd_en;
    logic              raise;
    logic              drop;
    logic [DATA_W-1:0] outa_q;
    logic [DATA_W-1:0] outb_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] swirq_q;

    assign wr_en = bus_valid &  bus_write;
    assign rd_en = bus_valid & ~bus_write;

    itr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    itr_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (bus_wdata),
        .outa_q  (outa_q),
        .outb_q  (outb_q),
        .ctrl_q  (ctrl_q),
        .stat_q  (stat_q),
        .swirq_q (swirq_q)
    );

    always_comb begin
        raise = 1'b0;
        drop  = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_OUTB:  raise = bus_wdata[OUTB_RAISE_BIT];
                SEL_SWSET: raise = 1'b1;
                SEL_CTRL:  drop  = bus_wdata[CTRL_DROP_BIT];
                SEL_STAT:  drop  = bus_wdata[STAT_DROP_LO] | bus_wdata[STAT_DROP_HI];
                SEL_SWCLR: drop  = 1'b1;
                SEL_OUTA, SEL_NONE: ;
            endcase
        end
    end

    itr_line_fsm u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (raise),
        .drop  (drop),
        .line  (irq_out)
    );

    itr_read_port #(
        .DATA_W         (DATA_W),
        .CTRL_FIXED_BIT (CTRL_FIXED_BIT)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (sel),
        .outa_q  (outa_q),
        .outb_q  (outb_q),
        .ctrl_q  (ctrl_q),
        .stat_q  (stat_q),
        .swirq_q (swirq_q),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/irq_trigger_regs_chk.sv
module irq_trigger_regs_chk
    import itr_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int DATA_W         = 32,
    parameter int CTRL_FIXED_BIT = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wd_outb_raise,
    input logic              wd_ctrl_drop,
    input logic              wd_stat_drop,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_out
);

    logic wr, rd, known;

    assign wr    = bus_valid &  bus_write;
    assign rd    = bus_valid & ~bus_write;
    assign known = (bus_addr == ADDR_W'(OFF_OUTA))  || (bus_addr == ADDR_W'(OFF_OUTB)) ||
                   (bus_addr == ADDR_W'(OFF_CTRL))  || (bus_addr == ADDR_W'(OFF_STAT)) ||
                   (bus_addr == ADDR_W'(OFF_SWSET)) || (bus_addr == ADDR_W'(OFF_SWCLR));

    p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !irq_out);

    p_ctrl_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd && bus_addr == ADDR_W'(OFF_CTRL) |=> bus_rdata[CTRL_FIXED_BIT]);

    p_outb_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == ADDR_W'(OFF_OUTB) && wd_outb_raise |=> irq_out);

    p_ctrl_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == ADDR_W'(OFF_CTRL) && wd_ctrl_drop |=> !irq_out);

    p_stat_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == ADDR_W'(OFF_STAT) && wd_stat_drop |=> !irq_out);

    p_swset_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == ADDR_W'(OFF_SWSET) |=> irq_out);

    p_swclr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == ADDR_W'(OFF_SWCLR) |=> !irq_out);

    p_unknown_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !known |=> bus_rdata == '0);

    p_unknown_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !known |=> $stable(irq_out));

    p_line_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(irq_out));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));

endmodule

bind irq_trigger_regs irq_trigger_regs_chk #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .CTRL_FIXED_BIT (CTRL_FIXED_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .wd_outb_raise (bus_wdata[OUTB_RAISE_BIT]),
    .wd_ctrl_drop  (bus_wdata[CTRL_DROP_BIT]),
    .wd_stat_drop  (bus_wdata[STAT_DROP_LO] | bus_wdata[STAT_DROP_HI]),
    .bus_rdata     (bus_rdata),
    .irq_out       (irq_out)
);

// File: tb/irq_trigger_regs_test.sv
module irq_trigger_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_trigger_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic        chk_rd;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h028, 32'hDEADBEEF, 1'b0, 32'h0,        1'b0, 8'd3},  // R3
        '{1'b0, 12'h028, 32'h0,        1'b1, 32'hDEADBEEF, 1'b0, 8'd3},  // R3
        '{1'b1, 12'h02C, 32'h10000001, 1'b0, 32'h0,        1'b0, 8'd4},  // R4 no bit 29
        '{1'b0, 12'h02C, 32'h0,        1'b1, 32'h10000001, 1'b0, 8'd3},  // R3
        '{1'b1, 12'h02C, 32'h20000005, 1'b0, 32'h0,        1'b1, 8'd4},  // R4 raise
        '{1'b0, 12'h02C, 32'h0,        1'b1, 32'h20000005, 1'b1, 8'd11}, // R11 read holds line
        '{1'b1, 12'h04C, 32'h000000FF, 1'b0, 32'h0,        1'b1, 8'd5},  // R5 no bit 16
        '{1'b0, 12'h04C, 32'h0,        1'b1, 32'h000200FF, 1'b1, 8'd2},  // R2
        '{1'b1, 12'h04C, 32'h00010003, 1'b0, 32'h0,        1'b0, 8'd5},  // R5 drop
        '{1'b0, 12'h04C, 32'h0,        1'b1, 32'h00030003, 1'b0, 8'd2},  // R2
        '{1'b1, 12'h050, 32'h00001234, 1'b0, 32'h0,        1'b0, 8'd6},  // R6 no drop bits
        '{1'b1, 12'h1F0, 32'h00000011, 1'b0, 32'h0,        1'b1, 8'd7},  // R7
        '{1'b1, 12'h050, 32'h20000000, 1'b0, 32'h0,        1'b0, 8'd6},  // R6 bit 29
        '{1'b0, 12'h050, 32'h0,        1'b1, 32'h20000000, 1'b0, 8'd3},  // R3
        '{1'b1, 12'h1F0, 32'h00000100, 1'b0, 32'h0,        1'b1, 8'd7},  // R7 OR
        '{1'b0, 12'h1F0, 32'h0,        1'b1, 32'h00000111, 1'b1, 8'd9},  // R9 set offset
        '{1'b1, 12'h050, 32'h00010000, 1'b0, 32'h0,        1'b0, 8'd6},  // R6 bit 16
        '{1'b1, 12'h1F0, 32'h00000000, 1'b0, 32'h0,        1'b1, 8'd7},  // R7 zero data
        '{1'b1, 12'h1F4, 32'h00000000, 1'b0, 32'h0,        1'b0, 8'd8},  // R8 zero data
        '{1'b0, 12'h1F4, 32'h0,        1'b1, 32'h00000111, 1'b0, 8'd9},  // R9 clear offset
        '{1'b1, 12'h1F4, 32'h00000101, 1'b0, 32'h0,        1'b0, 8'd8},  // R8 AND-NOT
        '{1'b0, 12'h1F0, 32'h0,        1'b1, 32'h00000010, 1'b0, 8'd8},  // R8
        '{1'b1, 12'h02C, 32'h20000000, 1'b0, 32'h0,        1'b1, 8'd4},  // R4
        '{1'b1, 12'h030, 32'hFFFFFFFF, 1'b0, 32'h0,        1'b1, 8'd10}, // R10
        '{1'b0, 12'h030, 32'h0,        1'b1, 32'h00000000, 1'b1, 8'd10}, // R10
        '{1'b1, 12'h1F8, 32'h00010000, 1'b0, 32'h0,        1'b1, 8'd10}, // R10
        '{1'b0, 12'h028, 32'h0,        1'b1, 32'hDEADBEEF, 1'b1, 8'd10}, // R10 no corruption
        '{1'b1, 12'h1F4, 32'hFFFFFFFF, 1'b0, 32'h0,        1'b0, 8'd8}   // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = addr;
        bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1", {31'b0, irq_out}, 32'h0);
        check("R1", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {31'b0, irq_out}, 32'h0);
        access(1'b0, 12'h04C, '0);
        check("R1", bus_rdata, 32'h00020000);
        access(1'b0, 12'h1F0, '0);
        check("R1", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].data);
            check($sformatf("R%0d irq vec%0d", VECS[i].req, i), {31'b0, irq_out}, {31'b0, VECS[i].exp_irq});
            if (VECS[i].chk_rd)
                check($sformatf("R%0d rdata vec%0d", VECS[i].req, i), bus_rdata, VECS[i].exp_rd);
        end

        // R12: no change before the edge, update after it, hold across writes
        access(1'b0, 12'h028, '0);
        check("R12", bus_rdata, 32'hDEADBEEF);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = 12'h050;
        #1;
        check("R12", bus_rdata, 32'hDEADBEEF);
        @(negedge clk);
        bus_valid = 1'b0;
        check("R12", bus_rdata, 32'h00010000);
        access(1'b1, 12'h028, 32'h12345678);
        check("R12", bus_rdata, 32'h00010000);
        repeat (3) @(negedge clk);
        check("R12", bus_rdata, 32'h00010000);

        // R11: idle cycles with line high
        access(1'b1, 12'h1F0, 32'h1);
        repeat (4) @(negedge clk);
        check("R11", {31'b0, irq_out}, 32'h1);

        // R1: reset in mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {31'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 12'h1F4, '0);
        check("R1", bus_rdata, 32'h0);
        access(1'b0, 12'h028, '0);
        check("R1", bus_rdata, 32'h0);
        access(1'b0, 12'h04C, '0);
        check("R1", bus_rdata, 32'h00020000);
        check("R1", {31'b0, irq_out}, 32'h0);

        finish_run();
    end

endmodule